// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block pairs an 8-bit timer/counter with a watchdog counter. Both draw on a single 8-bit prescaler, and one mode input decides which of the two receives it. Whichever counter does not own the prescaler counts raw, undivided ticks.

The timer can count internal instruction-cycle ticks. These are the system clock divided by 2 or by 4, and a phase counter that starts at zero on reset sets their timing. The timer can also count edges from an external pin. The pin passes through a two-flop synchronizer, and a select input chooses whether its rising or falling edge counts. A bus write loads the timer directly. When the timer wraps from all ones to zero it sets an interrupt flag, and the flag stays set until software clears it.

The watchdog counts enables from a free-running slow clock input. When it is enabled and it wraps, it produces a one-cycle reset pulse. A watchdog-clear strobe or a sleep strobe restarts it. The prescaler is cleared by a different event depending on its owner: a timer write when the timer owns it, and a watchdog clear, a sleep strobe or a timeout when the watchdog owns it. The reset input is expected to be asserted asynchronously and released in step with the clock.

Top module: `tmr_wdog_core`

## Requirements
- R1: While reset is asserted, `tmr_value` is 0, `irq_flag` is 0 and `wdog_rst` is 0.
- R2: The internal tick comes from a 2-bit phase counter that is 0 on the first edge after reset and advances every clock. With `cfg_div4`=0 the tick is active when the phase is odd, so on every 2nd edge after reset. With `cfg_div4`=1 it is active when the phase is 3, so on every 4th edge.
- R3: With `cfg_ps_owner`=0, the timer advances once per 2^(`cfg_ratio`+1) source ticks, which gives 1:2 for ratio 0 and 1:256 for ratio 7. With `cfg_ps_owner`=1, the timer advances on every source tick.
- R4: A cycle with `bus_wr`=1 loads `bus_wdata` into the timer on that edge. The write takes priority over any tick in the same cycle.
- R5: When `cfg_ps_owner`=0, a bus write also clears the prescaler, so that the next timer advance needs a full prescale period.
- R6: When the timer advances from 0xFF to 0x00, `irq_flag` is set. It stays set until a cycle with `irq_clr`=1 clears it.
- R7: With `cfg_src_ext`=1 the timer counts `ext_pin` edges: rising edges when `cfg_edge_fall`=0 and falling edges when it is 1. A pin change that is applied before edge a shows up in `tmr_value` after edge a+2.
- R8: With `cfg_ps_owner`=0, the watchdog advances on each `slow_tick`. After 2^WDOG_W advances without a clear, `wdog_rst` is high for exactly one cycle, and counting resumes from zero.
- R9: With `cfg_ps_owner`=1, the watchdog advances once per 2^`cfg_ratio` slow ticks. A timeout clears the prescaler as well.
- R10: `wdog_clr` or `sleep_stb` clears the watchdog counter. When `cfg_ps_owner`=1, either strobe also clears the prescaler.
- R11: While `wdog_en`=0 the watchdog counter is held at zero and `wdog_rst` stays low. Once enabled, the first timeout follows 2^WDOG_W advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_div4 | input | 1 | Internal tick divider: 0 = clock/2, 1 = clock/4 |
| cfg_src_ext | input | 1 | Timer source: 0 = internal tick, 1 = external pin |
| cfg_edge_fall | input | 1 | Pin edge: 0 = rising, 1 = falling |
| cfg_ps_owner | input | 1 | Prescaler owner: 0 = timer, 1 = watchdog |
| cfg_ratio | input | 3 | Prescaler stage select |
| wdog_en | input | 1 | Watchdog enable |
| ext_pin | input | 1 | Asynchronous external count pin |
| slow_tick | input | 1 | Watchdog clock enable from the slow oscillator |
| bus_wr | input | 1 | Timer write strobe |
| bus_wdata | input | 8 | Timer write data |
| wdog_clr | input | 1 | Watchdog clear strobe |
| sleep_stb | input | 1 | Sleep strobe, which clears the watchdog |
| irq_clr | input | 1 | Clears the overflow flag |
| tmr_value | output | 8 | Current timer value |
| irq_flag | output | 1 | Sticky timer overflow flag |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that `bus_wr`, `wdog_clr`, `sleep_stb` and `irq_clr` are single-cycle strobes sampled at the clock. They also assume that configuration inputs change only while the block is in reset, so that no prescaler re-routing happens in the middle of a count. The stimulus follows this by applying every configuration inside a reset sequence and driving each strobe for one cycle at the falling clock edge. Only `ext_pin` changes out of step with the counted edges, and the synchronizer takes care of it.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // Which counter receives the divided tick
  typedef enum logic {
    PS_TO_TMR = 1'b0,
    PS_TO_WDG = 1'b1
  } ps_owner_e;

endpackage

// File: rtl/tw_tick_gen.sv
module tw_tick_gen #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div4,
  input  logic src_ext,
  input  logic edge_fall,
  input  logic pin,
  output logic src_tick
);

  logic [1:0]      phase_q, phase_d;
  logic [SYNC_N:0] sync_q, sync_d;
  logic            int_tick;
  logic            pin_rise, pin_fall, ext_tick;

  // free-running phase counter for the internal instruction tick
  always_comb begin
    phase_d = phase_q + 2'd1;
  end

  // synchronizer chain plus one extra stage for edge detection
  always_comb begin
    sync_d = {sync_q[SYNC_N-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sync_q  <= '0;
    end else begin
      phase_q <= phase_d;
      sync_q  <= sync_d;
    end
  end

  always_comb begin
    int_tick = div4 ? (phase_q == 2'b11) : phase_q[0];
    pin_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    pin_fall = ~sync_q[SYNC_N-1] & sync_q[SYNC_N];
    ext_tick = edge_fall ? pin_fall : pin_rise;
    src_tick = src_ext ? ext_tick : int_tick;
  end

endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler
  import tw_pkg::*;
#(
  parameter int PS_W  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tick,
  input  logic             clr,
  input  ps_owner_e        owner,
  input  logic [SEL_W-1:0] ratio,
  output logic             out_tick
);

  logic [PS_W-1:0] cnt_q, cnt_d;
  logic [PS_W:0]   stage_full;
  logic [SEL_W:0]  stage_idx;

  // stage_full[k]: the low k bits are all ones, so the next tick carries out of bit k-1
  genvar k;
  generate
    for (k = 0; k <= PS_W; k++) begin : g_stage
      if (k == 0) begin : g_pass
        assign stage_full[k] = 1'b1;
      end else begin : g_and
        assign stage_full[k] = &cnt_q[k-1:0];
      end
    end
  endgenerate

  // the timer skips the undivided stage, the watchdog may use it
  always_comb begin
    if (owner == PS_TO_TMR) begin
      stage_idx = {1'b0, ratio} + {{SEL_W{1'b0}}, 1'b1};
    end else begin
      stage_idx = {1'b0, ratio};
    end
    out_tick = in_tick & stage_full[stage_idx];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (in_tick) begin
      cnt_d = cnt_q + {{(PS_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         irq_clr,
  output logic [W-1:0] value,
  output logic         irq
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] val_q, val_d;
  logic         irq_q, irq_d;
  logic         wrap;

  always_comb begin
    wrap  = tick & ~wr & (val_q == TOP);
    val_d = val_q;
    if (wr) begin
      val_d = wdata;
    end else if (tick) begin
      val_d = val_q + {{(W-1){1'b0}}, 1'b1};
    end
    // a new overflow wins over a clear in the same cycle
    irq_d = irq_q;
    if (wrap) begin
      irq_d = 1'b1;
    end else if (irq_clr) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      irq_q <= 1'b0;
    end else begin
      val_q <= val_d;
      irq_q <= irq_d;
    end
  end

  assign value = val_q;
  assign irq   = irq_q;

endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic clr,
  output logic expire,
  output logic rst_pulse
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_q, pulse_d;

  always_comb begin
    expire = en & tick & ~clr & (cnt_q == TOP);
    cnt_d  = cnt_q;
    if (clr || !en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    end
    pulse_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign rst_pulse = pulse_q;

endmodule

// File: rtl/tmr_wdog_core.sv
module tmr_wdog_core
  import tw_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int PS_W   = 8,
  parameter int WDOG_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_div4,
  input  logic                     cfg_src_ext,
  input  logic                     cfg_edge_fall,
  input  logic                     cfg_ps_owner,
  input  logic [$clog2(PS_W)-1:0]  cfg_ratio,
  input  logic                     wdog_en,
  input  logic                     ext_pin,
  input  logic                     slow_tick,
  input  logic                     bus_wr,
  input  logic [TMR_W-1:0]         bus_wdata,
  input  logic                     wdog_clr,
  input  logic                     sleep_stb,
  input  logic                     irq_clr,
  output logic [TMR_W-1:0]         tmr_value,
  output logic                     irq_flag,
  output logic                     wdog_rst
);

  localparam int SEL_W = $clog2(PS_W);

  ps_owner_e owner;
  logic      src_tick;
  logic      ps_in, ps_out, ps_clr;
  logic      tmr_tick, wd_tick, wd_clr, wd_expire;

  assign owner = ps_owner_e'(cfg_ps_owner);

  tw_tick_gen #(.SYNC_N(SYNC_N)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .div4      (cfg_div4),
    .src_ext   (cfg_src_ext),
    .edge_fall (cfg_edge_fall),
    .pin       (ext_pin),
    .src_tick  (src_tick)
  );

  // routing around the shared prescaler
  always_comb begin
    wd_clr = wdog_clr | sleep_stb;
    if (owner == PS_TO_TMR) begin
      ps_in    = src_tick;
      ps_clr   = bus_wr;
      tmr_tick = ps_out;
      wd_tick  = slow_tick;
    end else begin
      ps_in    = slow_tick;
      ps_clr   = wd_clr | wd_expire;
      tmr_tick = src_tick;
      wd_tick  = ps_out;
    end
  end

  tw_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_tick  (ps_in),
    .clr      (ps_clr),
    .owner    (owner),
    .ratio    (cfg_ratio),
    .out_tick (ps_out)
  );

  tw_timer #(.W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tmr_tick),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .irq_clr (irq_clr),
    .value   (tmr_value),
    .irq     (irq_flag)
  );

  tw_watchdog #(.W(WDOG_W)) u_wdg (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (wd_tick),
    .en        (wdog_en),
    .clr       (wd_clr),
    .expire    (wd_expire),
    .rst_pulse (wdog_rst)
  );

endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdog_en,
  input logic             bus_wr,
  input logic [TMR_W-1:0] bus_wdata,
  input logic             wdog_clr,
  input logic             sleep_stb,
  input logic             irq_clr,
  input logic [TMR_W-1:0] tmr_value,
  input logic             irq_flag,
  input logic             wdog_rst
);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);  // R8

  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> $past(wdog_en));  // R11

  AST_CLR_BLOCKS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_clr || sleep_stb) |=> !wdog_rst);  // R10

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (tmr_value == $past(bus_wdata)));  // R4

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (tmr_value == $past(tmr_value)) ||
                (tmr_value == TMR_W'($past(tmr_value) + 1'b1)));  // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);  // R6

  AST_IRQ_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (tmr_value == '0));  // R6

endmodule

bind tmr_wdog_core tw_checker #(.TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wdog_en   (wdog_en),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .wdog_clr  (wdog_clr),
  .sleep_stb (sleep_stb),
  .irq_clr   (irq_clr),
  .tmr_value (tmr_value),
  .irq_flag  (irq_flag),
  .wdog_rst  (wdog_rst)
);

// File: tb/tmr_wdog_core_test.sv
module tmr_wdog_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_div4 = 1'b0, cfg_src_ext = 1'b0, cfg_edge_fall = 1'b0, cfg_ps_owner = 1'b0;
  logic [2:0] cfg_ratio = 3'd0;
  logic       wdog_en = 1'b0, ext_pin = 1'b0, slow_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       wdog_clr = 1'b0, sleep_stb = 1'b0, irq_clr = 1'b0;
  logic [7:0] tmr_value;
  logic       irq_flag, wdog_rst;

  int total = 0;
  int bad = 0;
  int rst_seen = 0;

  always #5 clk = ~clk;

  tmr_wdog_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_div4(cfg_div4), .cfg_src_ext(cfg_src_ext),
    .cfg_edge_fall(cfg_edge_fall), .cfg_ps_owner(cfg_ps_owner), .cfg_ratio(cfg_ratio),
    .wdog_en(wdog_en), .ext_pin(ext_pin), .slow_tick(slow_tick), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .wdog_clr(wdog_clr), .sleep_stb(sleep_stb), .irq_clr(irq_clr),
    .tmr_value(tmr_value), .irq_flag(irq_flag), .wdog_rst(wdog_rst)
  );

  // count reset pulses shortly after each edge
  always @(posedge clk) begin
    #2;
    if (wdog_rst === 1'b1) rst_seen++;
  end

  // {div4, owner, ratio[2:0], cycles[10:0], expected timer[7:0], expected irq}
  localparam int N_VEC = 8;
  localparam logic [24:0] VECS [N_VEC] = '{
    {1'b0, 1'b1, 3'd0, 11'd100,  8'd50, 1'b0},
    {1'b1, 1'b1, 3'd0, 11'd100,  8'd25, 1'b0},
    {1'b0, 1'b0, 3'd0, 11'd100,  8'd25, 1'b0},
    {1'b0, 1'b0, 3'd2, 11'd200,  8'd12, 1'b0},
    {1'b1, 1'b0, 3'd1, 11'd400,  8'd25, 1'b0},
    {1'b0, 1'b1, 3'd0, 11'd600,  8'd44, 1'b1},
    {1'b0, 1'b0, 3'd7, 11'd1030, 8'd2,  1'b0},
    {1'b1, 1'b0, 3'd0, 11'd64,   8'd8,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // holds reset for two cycles, applies the configuration, releases at a falling edge
  task automatic do_reset(input logic div4, input logic owner, input logic ext,
                          input logic fall, input logic [2:0] ratio, input logic en);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_div4 = div4; cfg_ps_owner = owner; cfg_src_ext = ext;
    cfg_edge_fall = fall; cfg_ratio = ratio; wdog_en = en;
    bus_wr = 1'b0; wdog_clr = 1'b0; sleep_stb = 1'b0; irq_clr = 1'b0; ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;

    // R1 reset state
    @(negedge clk);
    chk("R1 tmr in reset", tmr_value, 0);
    chk("R1 irq in reset", irq_flag, 0);
    chk("R1 wdog_rst in reset", wdog_rst, 0);

    // table: R2 internal divider, R3 prescaler ratios, R6 overflow flag
    for (int i = 0; i < N_VEC; i++) begin
      do_reset(VECS[i][24], VECS[i][23], 1'b0, 1'b0, VECS[i][22:20], 1'b0);
      edges(int'(VECS[i][19:9]));
      chk("R2/R3 table timer value", tmr_value, VECS[i][8:1]);
      chk("R6 table irq flag", irq_flag, VECS[i][0]);
    end

    // R4 write load, R6 overflow and clear
    do_reset(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    bus_wr = 1'b1; bus_wdata = 8'hFE;
    edges(1);
    bus_wr = 1'b0;
    chk("R4 write loads", tmr_value, 8'hFE);
    edges(2);
    chk("R6 before wrap value", tmr_value, 8'hFF);
    chk("R6 before wrap irq", irq_flag, 0);
    edges(1);
    chk("R6 wrap value", tmr_value, 8'h00);
    chk("R6 wrap sets irq", irq_flag, 1);
    edges(10);
    chk("R6 irq held", irq_flag, 1);
    irq_clr = 1'b1;
    edges(1);
    irq_clr = 1'b0;
    chk("R6 irq cleared", irq_flag, 0);
    // edge 16 carries a tick; the write must win
    bus_wr = 1'b1; bus_wdata = 8'h80;
    edges(1);
    bus_wr = 1'b0;
    chk("R4 write beats tick", tmr_value, 8'h80);

    // R5 write clears the timer-owned prescaler (1:8)
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0);
    edges(12);
    bus_wr = 1'b1; bus_wdata = 8'h10;
    edges(1);
    bus_wr = 1'b0;
    edges(7);
    chk("R5 no early advance", tmr_value, 8'h10);
    edges(7);
    chk("R5 still held at edge 27", tmr_value, 8'h10);
    edges(1);
    chk("R5 full period after write", tmr_value, 8'h11);

    // R7 external rising edges
    do_reset(1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0);
    edges(3);
    ext_pin = 1'b1;
    edges(2);
    chk("R7 sync latency", tmr_value, 0);
    edges(1);
    chk("R7 first rise counted", tmr_value, 1);
    edges(2);
    ext_pin = 1'b0;
    edges(3);
    for (int p = 0; p < 4; p++) begin
      ext_pin = 1'b1; edges(3);
      ext_pin = 1'b0; edges(3);
    end
    edges(3);
    chk("R7 rising count", tmr_value, 5);

    // R7 external falling edges
    do_reset(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0);
    edges(3);
    ext_pin = 1'b1;
    edges(4);
    chk("R7 rise ignored in fall mode", tmr_value, 0);
    ext_pin = 1'b0;
    edges(3);
    for (int p = 0; p < 4; p++) begin
      ext_pin = 1'b1; edges(3);
      ext_pin = 1'b0; edges(3);
    end
    edges(3);
    chk("R7 falling count", tmr_value, 5);

    // R8 raw watchdog timeout
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    slow_tick = 1'b1;
    base = rst_seen;
    edges(255);
    chk("R8 no pulse before timeout", rst_seen - base, 0);
    edges(1);
    chk("R8 pulse at timeout", wdog_rst, 1);
    edges(1);
    chk("R8 pulse one cycle", wdog_rst, 0);
    edges(254);
    chk("R8 restart from zero", wdog_rst, 0);
    edges(1);
    chk("R8 second timeout", wdog_rst, 1);

    // R10 watchdog clear strobe
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    base = rst_seen;
    edges(200);
    wdog_clr = 1'b1;
    edges(1);
    wdog_clr = 1'b0;
    edges(255);
    chk("R10 clear delays timeout", rst_seen - base, 0);
    edges(1);
    chk("R10 timeout after clear", wdog_rst, 1);

    // R10 sleep strobe
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    base = rst_seen;
    edges(99);
    sleep_stb = 1'b1;
    edges(1);
    sleep_stb = 1'b0;
    edges(255);
    chk("R10 sleep delays timeout", rst_seen - base, 0);
    edges(1);
    chk("R10 timeout after sleep", wdog_rst, 1);

    // R9 watchdog-owned prescaler 1:2
    do_reset(1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b1);
    edges(511);
    chk("R9 before prescaled timeout", wdog_rst, 0);
    edges(1);
    chk("R9 prescaled timeout", wdog_rst, 1);

    // R10 clear also clears the watchdog-owned prescaler
    do_reset(1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b1);
    base = rst_seen;
    edges(200);
    wdog_clr = 1'b1;
    edges(1);
    wdog_clr = 1'b0;
    edges(511);
    chk("R10 prescaler cleared too", rst_seen - base, 0);
    edges(1);
    chk("R10 timeout after full period", wdog_rst, 1);

    // R11 disabled watchdog holds at zero
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    base = rst_seen;
    edges(600);
    chk("R11 no pulse while disabled", rst_seen - base, 0);
    wdog_en = 1'b1;
    edges(255);
    chk("R11 full period after enable", rst_seen - base, 0);
    edges(1);
    chk("R11 timeout after enable", wdog_rst, 1);

    slow_tick = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule